// File: doc/BRIEF.md
# Level Interrupt Combiner with APB Register Access

This block gathers a parameterised number of level-sensitive interrupt lines (2 to 64) and folds them into a single interrupt request for an upstream interrupt controller. Each line has an enable bit and a block bit, both writable over an APB slave port. A line is reported as pending while its synchronised input is high, its enable bit is 1 and its block bit is 0. The pending lines can be read as two 32-bit status words, so an interrupt handler can walk them one by one.

Every 64-bit register appears as a low word and a high word. Bits for lines that are not built do not exist: they read back as 0 even after a write of all ones. Software can therefore find the configured line count by writing all ones to the enable words and reading them back. When 32 or fewer lines are built, the high enable word always reads 0, and software then knows it needs only the low status word. The incoming lines pass through a two-flop synchroniser before they are gated.

Top module: `irq_combiner`

## Requirements
- R1: After reset, all enable and block bits are 0, both status words read 0 and `irq_out` is 0.
- R2: The enable register is 64 bits: bits 31..0 at byte offset 0x00 and bits 63..32 at 0x04. Bits at or above NUM_SRC always read 0, so the word at 0x04 reads 0 whenever NUM_SRC is 32 or less.
- R3: The block register is 64 bits: bits 31..0 at offset 0x08 and bits 63..32 at 0x0C. A 1 blocks the line and a 0 passes it. Bits at or above NUM_SRC read 0.
- R4: The status word at 0x30 holds lines 0..31 and the word at 0x34 holds lines 32..63, with line n in bit n mod 32. A bit is 1 exactly when the synchronised input is 1, the enable bit is 1 and the block bit is 0.
- R5: A change on `irq_src` appears in the status and in `irq_out` after exactly two rising clock edges.
- R6: `irq_out` is the OR of all status bits. It is 0 whenever every enable bit is 0.
- R7: Inputs are level-sensitive. A status bit stays 1 for as long as its input stays high, and it returns to 0 two clocks after the input falls.
- R8: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x30 and 0x34 return 0, and writes to those offsets change nothing. The status words are read-only.
- R9: `pready` is always 1 and `pslverr` is always 0 (no wait states, no errors).
- R10: A register is written only in the APB access phase (`psel`, `penable` and `pwrite` all 1). A setup phase on its own writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Transfer error (always 0) |
| irq_src | input | NUM_SRC | Level interrupt inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The latency assertion assumes that `irq_src` only changes away from the rising clock edge, so the value sampled at an edge is the one the synchroniser captures. It also relies on reset being held long enough that the first two edges after release start from a cleared pipeline. The write-tracking assertions assume that `psel` stays high across each setup and access pair. The bench meets these assumptions by driving every input on the falling edge and by running each APB transfer as one setup cycle followed by one access cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int WORD_W = 32;
    localparam int VEC_W  = 64;

    // word offsets decoded from paddr[5:0]
    localparam logic [5:0] OFS_EN_LO  = 6'h00;
    localparam logic [5:0] OFS_EN_HI  = 6'h04;
    localparam logic [5:0] OFS_BLK_LO = 6'h08;
    localparam logic [5:0] OFS_BLK_HI = 6'h0C;
    localparam logic [5:0] OFS_ST_LO  = 6'h30;
    localparam logic [5:0] OFS_ST_HI  = 6'h34;

    typedef struct packed {
        logic [VEC_W-1:0] en;
        logic [VEC_W-1:0] blk;
    } ctl_regs_t;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/irqc_gate.sv
`timescale 1ns/1ps
module irqc_gate import irqc_pkg::*; #(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] src_s,
    input  logic [VEC_W-1:0]   en,
    input  logic [VEC_W-1:0]   blk,
    output logic [VEC_W-1:0]   fin,
    output logic               any
);
    logic [VEC_W-1:0] src_ext;
    assign src_ext = VEC_W'(src_s);

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        assign fin[i] = src_ext[i] & en[i] & ~blk[i];
    end

    assign any = |fin;
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs import irqc_pkg::*; #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [WORD_W-1:0] pwdata,
    input  logic [VEC_W-1:0]  fin_stat,
    output logic [WORD_W-1:0] prdata,
    output logic [VEC_W-1:0]  en_o,
    output logic [VEC_W-1:0]  blk_o
);
    localparam logic [VEC_W:0]   LIM  = (65'd1 << NUM_SRC) - 65'd1;
    localparam logic [VEC_W-1:0] IMPL = LIM[VEC_W-1:0];

    ctl_regs_t rg_d, rg_q;
    logic       in_range;
    logic [5:0] ofs;
    logic       wr_hit;
    logic       rd_hit;

    always_comb begin
        in_range = (paddr[ADDR_W-1:6] == '0);
        ofs      = paddr[5:0];
        wr_hit   = psel & penable & pwrite & in_range;
        rd_hit   = psel & ~pwrite & in_range;

        rg_d = rg_q;
        if (wr_hit) begin
            case (ofs)
                OFS_EN_LO:  rg_d.en[31:0]   = pwdata & IMPL[31:0];
                OFS_EN_HI:  rg_d.en[63:32]  = pwdata & IMPL[63:32];
                OFS_BLK_LO: rg_d.blk[31:0]  = pwdata & IMPL[31:0];
                OFS_BLK_HI: rg_d.blk[63:32] = pwdata & IMPL[63:32];
                default: ;
            endcase
        end

        prdata = '0;
        if (rd_hit) begin
            case (ofs)
                OFS_EN_LO:  prdata = rg_q.en[31:0];
                OFS_EN_HI:  prdata = rg_q.en[63:32];
                OFS_BLK_LO: prdata = rg_q.blk[31:0];
                OFS_BLK_HI: prdata = rg_q.blk[63:32];
                OFS_ST_LO:  prdata = fin_stat[31:0];
                OFS_ST_HI:  prdata = fin_stat[63:32];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign en_o  = rg_q.en;
    assign blk_o = rg_q.blk;
endmodule

// File: rtl/irq_combiner.sv
`timescale 1ns/1ps
module irq_combiner import irqc_pkg::*; #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic              irq_out
);
    logic [NUM_SRC-1:0] src_s;
    logic [VEC_W-1:0]   fin_vec;
    logic [VEC_W-1:0]   en_vec;
    logic [VEC_W-1:0]   blk_vec;

    irqc_sync #(.W(NUM_SRC)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (irq_src),
        .q     (src_s)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .fin_stat (fin_vec),
        .prdata   (prdata),
        .en_o     (en_vec),
        .blk_o    (blk_vec)
    );

    irqc_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .src_s (src_s),
        .en    (en_vec),
        .blk   (blk_vec),
        .fin   (fin_vec),
        .any   (irq_out)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/irq_combiner_chk.sv
`timescale 1ns/1ps
module irq_combiner_chk #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input logic               pclk,
    input logic               presetn,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        pwdata,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               irq_out,
    input logic [63:0]        en_vec,
    input logic [63:0]        blk_vec
);
    localparam logic [64:0] LIM  = (65'd1 << NUM_SRC) - 65'd1;
    localparam logic [63:0] IMPL = LIM[63:0];

    logic [1:0] warm_q;
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)           warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2: a low enable write lands next cycle, trimmed to built lines
    a_r2_en_lo_write: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(8'h00))
        |=> en_vec[31:0] == ($past(pwdata) & IMPL[31:0]));

    // R3: a high block write lands next cycle, trimmed to built lines
    a_r3_blk_hi_write: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(8'h0C))
        |=> blk_vec[63:32] == ($past(pwdata) & IMPL[63:32]));

    // R10: a setup cycle changes no control state
    a_r10_setup_quiet: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !penable) |=> ($stable(en_vec) && $stable(blk_vec)));

    // R6: no enabled line means no request
    a_r6_idle_when_off: assert property (@(posedge pclk) disable iff (!presetn)
        (en_vec == '0) |-> !irq_out);

    // R5: request follows the inputs two edges back
    a_r5_two_edge_lag: assert property (@(posedge pclk) disable iff (!presetn)
        (warm_q >= 2'd2)
        |-> irq_out == ((64'($past(irq_src, 2)) & en_vec & ~blk_vec) != 64'd0));
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_combiner_tb_top;
    localparam int NA = 40;
    localparam int NB = 20;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tgt = 1'b0;
    logic [NA-1:0] src_a = '0;
    logic [NB-1:0] src_b = '0;
    logic [31:0] rd_a, rd_b;
    logic        rdy_a, rdy_b, err_a, err_b, irq_a, irq_b;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 pclk = ~pclk;

    irq_combiner #(.NUM_SRC(NA), .ADDR_W(8)) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel & ~tgt), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_a),
        .pready(rdy_a), .pslverr(err_a), .irq_src(src_a), .irq_out(irq_a));

    irq_combiner #(.NUM_SRC(NB), .ADDR_W(8)) dut_s (
        .pclk(pclk), .presetn(presetn), .psel(psel & tgt), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_b),
        .pready(rdy_b), .pslverr(err_b), .irq_src(src_b), .irq_out(irq_b));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apb(input logic t, input logic wr, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] r);
        @(negedge pclk);
        tgt = t; psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        r = t ? rd_b : rd_a;
        check("R9 pready", {31'd0, t ? rdy_b : rdy_a}, 32'd1);
        check("R9 pslverr", {31'd0, t ? err_b : err_a}, 32'd0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic t, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        apb(t, 1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic t, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r;
        apb(t, 1'b0, a, 32'd0, r);
        check(tag, r, exp);
    endtask

    task automatic t_reset();
        check("R1 irq_out", {31'd0, irq_a}, 32'd0);
        rd_chk("R1 en lo", 0, 8'h00, 0);
        rd_chk("R1 en hi", 0, 8'h04, 0);
        rd_chk("R1 blk lo", 0, 8'h08, 0);
        rd_chk("R1 blk hi", 0, 8'h0C, 0);
        rd_chk("R1 st lo", 0, 8'h30, 0);
        rd_chk("R1 st hi", 0, 8'h34, 0);
    endtask

    task automatic t_enable();
        wr(0, 8'h00, 32'hFFFF_FFFF);
        wr(0, 8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 en lo all", 0, 8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 en hi 40 lines", 0, 8'h04, 32'h0000_00FF);
        wr(1, 8'h00, 32'hFFFF_FFFF);
        wr(1, 8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 en lo 20 lines", 1, 8'h00, 32'h000F_FFFF);
        rd_chk("R2 en hi 20 lines", 1, 8'h04, 32'h0);
    endtask

    task automatic t_block();
        wr(0, 8'h08, 32'hA5A5_A5A5);
        wr(0, 8'h0C, 32'hFFFF_FFFF);
        rd_chk("R3 blk lo", 0, 8'h08, 32'hA5A5_A5A5);
        rd_chk("R3 blk hi", 0, 8'h0C, 32'h0000_00FF);
        wr(0, 8'h08, 32'h0);
        wr(0, 8'h0C, 32'h0);
        rd_chk("R3 blk cleared", 0, 8'h08, 32'h0);
    endtask

    task automatic t_gate();
        @(negedge pclk);
        src_a = '0; src_a[3] = 1'b1; src_a[35] = 1'b1;
        repeat (2) @(negedge pclk);
        rd_chk("R4 st lo", 0, 8'h30, 32'h0000_0008);
        rd_chk("R4 st hi", 0, 8'h34, 32'h0000_0008);
        check("R6 irq on", {31'd0, irq_a}, 32'd1);
        wr(0, 8'h08, 32'h0000_0008);
        rd_chk("R4 blocked lo", 0, 8'h30, 32'h0);
        check("R6 irq via line 35", {31'd0, irq_a}, 32'd1);
        wr(0, 8'h04, 32'h0);
        rd_chk("R4 disabled hi", 0, 8'h34, 32'h0);
        check("R6 irq off", {31'd0, irq_a}, 32'd0);
        wr(0, 8'h08, 32'h0);
        wr(0, 8'h04, 32'hFFFF_FFFF);
        @(negedge pclk);
        src_a = '0;
        repeat (2) @(negedge pclk);
        check("R6 irq idle", {31'd0, irq_a}, 32'd0);
    endtask

    task automatic t_level();
        @(negedge pclk);
        src_a[7] = 1'b1;
        @(negedge pclk);
        check("R5 one edge", {31'd0, irq_a}, 32'd0);
        @(negedge pclk);
        check("R5 two edges", {31'd0, irq_a}, 32'd1);
        repeat (10) @(negedge pclk);
        check("R7 held", {31'd0, irq_a}, 32'd1);
        rd_chk("R7 st held", 0, 8'h30, 32'h0000_0080);
        @(negedge pclk);
        src_a[7] = 1'b0;
        @(negedge pclk);
        check("R7 fall one edge", {31'd0, irq_a}, 32'd1);
        @(negedge pclk);
        check("R7 fall two edges", {31'd0, irq_a}, 32'd0);
    endtask

    task automatic t_unmapped();
        wr(0, 8'h10, 32'hFFFF_FFFF);
        rd_chk("R8 unmapped read", 0, 8'h10, 32'h0);
        wr(0, 8'h30, 32'hFFFF_FFFF);
        rd_chk("R8 status ro", 0, 8'h30, 32'h0);
        wr(0, 8'h48, 32'hFFFF_FFFF);
        rd_chk("R8 block untouched", 0, 8'h08, 32'h0);
        wr(0, 8'h80, 32'h0);
        rd_chk("R8 en untouched", 0, 8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_setup_only();
        @(negedge pclk);
        tgt = 0; psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0;
        @(negedge pclk);
        psel = 1'b0; pwrite = 1'b0;
        rd_chk("R10 setup no write", 0, 8'h00, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        repeat (2) @(negedge pclk);
        t_reset();
        t_enable();
        t_block();
        t_gate();
        t_level();
        t_unmapped();
        t_setup_only();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule